// File: doc/BRIEF.md
# Prioritized UART interrupt status register

This block collects the interrupt requests of a FIFO-equipped UART with software and hardware flow control, ranks them by a fixed priority and presents the winner as an encoded status byte. Neighbouring logic drives it. The receive path, line status logic, modem status logic and GPIO logic drive held request levels. The transmit path and the character matchers drive single-cycle event pulses. The host bus decoder drives a read strobe and the FIFO-enable bit of FIFO-control writes.

Eight sources are ranked. Five arrive as levels, and their owners clear them. The block itself holds the other three, and each has its own clearing rule:
- The transmit-ready request is dropped by a status read that reports it.
- The flow-character request is dropped either by a later Xon (when it was set by an Xoff) or by a read that reports it (when it was set by a special character).
- The flow-pin request is dropped by a read that reports it.

The flow-character and flow-pin sources both need the extended-features enable. The interrupt output is active-low and follows the live status, which tracks the inputs combinationally. The value the host reads is frozen at the start of each read strobe.

All pins are plain control and status signals. No stream handshake applies.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, `rd_data` is 0x01, `irq_n` is 1 and the FIFO bits 7:6 are 0.
- R2: Source rank, highest first: line status, receive time-out, receive data ready, transmit ready, modem status, GPIO, flow character, flow pin. Each has a status code in bits 5:0: 0x06, 0x0C, 0x04, 0x02, 0x00, 0x30, 0x10 and 0x20. Only the highest pending enabled source is reported.
- R3: Bit 0 of the status is 0 when an enabled source is pending and 1 otherwise. `irq_n` equals bit 0 of the live status at all times.
- R4: A FIFO-control write with `fcr_fifo_bit`=1 makes bits 7:6 read 11 in every status value. A write with 0 makes them read 00.
- R5: A transmit-empty event sets the transmit-ready request. A status read that reports code 0x02 clears it, and it stays clear until the next transmit-empty event.
- R6: A flow-character event (Xoff or special character) sets its request only while `ext_en`=1 and `irq_en[6]`=1. Otherwise it is ignored.
- R7: An Xoff-caused flow-character request is cleared by an Xon event and survives status reads. A special-character request is cleared by a read that reports it and is unaffected by Xon.
- R8: A flow-pin deassert event sets its request only while `ext_en`=1 and `irq_en[7]`=1. A read that reports code 0x20 clears it.
- R9: `rd_data` is loaded from the live status on the first cycle of a read strobe and holds for the rest of the strobe. A source arriving mid-read shows only on the next read.
- R10: Bit i of `irq_en` enables the source of rank i (0 = line status … 7 = flow pin). A pending source whose enable is 0 affects neither `irq_n` nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_ls | input | 1 | Receiver line status request (level) |
| req_rto | input | 1 | Receive time-out request (level) |
| req_rxrdy | input | 1 | Receive data ready request (level) |
| req_ms | input | 1 | Modem status request (level) |
| req_gpio | input | 1 | General-purpose input request (level) |
| ev_txe | input | 1 | Transmit-empty event pulse |
| ev_xoff | input | 1 | Xoff character matched pulse |
| ev_spec | input | 1 | Special character matched pulse |
| ev_xon | input | 1 | Xon character matched pulse |
| ev_flow | input | 1 | CTS or RTS deasserted pulse |
| irq_en | input | 8 | Per-source enables, bit = rank |
| ext_en | input | 1 | Extended-features enable |
| rd_stb | input | 1 | Status register read strobe |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_fifo_bit | input | 1 | Bit 0 of the FIFO-control write data |
| rd_data | output | 8 | Status byte captured at read start |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Any of these faults surfaces at the ports within one read:
- A latched request stuck set or stuck clear.
- A wrong rank or code.
- A clear that fires on the wrong read.

Such a fault shows as a wrong `rd_data` on the very next strobe. It also shows as an `irq_n` level that disagrees with bit 0 in the cycle after the faulty clock edge.

The clearing rules differ by source, so the bench drives each source through repeated reads. It checks that a reported code persists or vanishes exactly when its rule says. Gated events are checked by a read after the event, which confirms they left no trace.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 8;
  localparam int CODE_W = 6;

  localparam int RK_LS   = 0;
  localparam int RK_RTO  = 1;
  localparam int RK_RXR  = 2;
  localparam int RK_TX   = 3;
  localparam int RK_MS   = 4;
  localparam int RK_GPIO = 5;
  localparam int RK_XO   = 6;
  localparam int RK_FL   = 7;

  localparam logic [CODE_W-1:0] CODE_IDLE = 6'h01;

  function automatic logic [CODE_W-1:0] rank_code(input int rk);
    case (rk)
      RK_LS:   return 6'h06;
      RK_RTO:  return 6'h0C;
      RK_RXR:  return 6'h04;
      RK_TX:   return 6'h02;
      RK_MS:   return 6'h00;
      RK_GPIO: return 6'h30;
      RK_XO:   return 6'h10;
      default: return 6'h20;
    endcase
  endfunction
endpackage

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]      pend,
  output logic [N-1:0]      grant,
  output logic              any,
  output logic [CODE_W-1:0] code
);
  logic [N:0] above;

  assign above[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_rank
      assign grant[gi]   = pend[gi] & ~above[gi];
      assign above[gi+1] = above[gi] | pend[gi];
    end
  endgenerate

  assign any = above[N];

  always_comb begin
    code = any ? '0 : CODE_IDLE;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = code | rank_code(i);
    end
  end

  always_comb begin
    a_r2_onehot_grant: assert ($onehot0(grant));
    a_r3_any_grant: assert (any == (grant != '0));
  end
endmodule

// File: rtl/uirq_latch.sv
module uirq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_txe,
  input  logic ev_xoff,
  input  logic ev_spec,
  input  logic ev_xon,
  input  logic ev_flow,
  input  logic gate_xo,
  input  logic gate_fl,
  input  logic rd_rise,
  input  logic rep_tx,
  input  logic rep_xo,
  input  logic rep_fl,
  output logic tx_pend,
  output logic xo_pend,
  output logic fl_pend
);
  logic kind_spec;
  logic xo_set;
  logic fl_set;

  assign xo_set = gate_xo & (ev_xoff | ev_spec);
  assign fl_set = gate_fl & ev_flow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend <= 1'b0;
    end else if (ev_txe) begin
      tx_pend <= 1'b1;
    end else if (rd_rise && rep_tx) begin
      tx_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xo_pend   <= 1'b0;
      kind_spec <= 1'b0;
    end else if (xo_set) begin
      xo_pend   <= 1'b1;
      kind_spec <= ev_spec;
    end else if (!kind_spec && ev_xon) begin
      xo_pend <= 1'b0;
    end else if (kind_spec && rd_rise && rep_xo) begin
      xo_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_pend <= 1'b0;
    end else if (fl_set) begin
      fl_pend <= 1'b1;
    end else if (rd_rise && rep_fl) begin
      fl_pend <= 1'b0;
    end
  end

  a_r5_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && rep_tx && !ev_txe) |=> !tx_pend);
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_pend && !ev_txe) |=> !tx_pend);
  a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_xo && !xo_pend) |=> !xo_pend);
  a_r7_xoff_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (xo_pend && !kind_spec && !ev_xon) |=> xo_pend);
  a_r8_flow_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_fl && !fl_pend) |=> !fl_pend);
endmodule

// File: rtl/uirq_fcr.sv
module uirq_fcr (
  input  logic clk,
  input  logic rst_n,
  input  logic fcr_wr,
  input  logic fcr_fifo_bit,
  output logic fifo_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_en <= 1'b0;
    else if (fcr_wr) fifo_en <= fcr_fifo_bit;
  end

  a_r4_fifo_load: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr |=> (fifo_en == $past(fcr_fifo_bit)));
  a_r4_fifo_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !fcr_wr |=> $stable(fifo_en));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_ls,
  input  logic            req_rto,
  input  logic            req_rxrdy,
  input  logic            req_ms,
  input  logic            req_gpio,
  input  logic            ev_txe,
  input  logic            ev_xoff,
  input  logic            ev_spec,
  input  logic            ev_xon,
  input  logic            ev_flow,
  input  logic [NSRC-1:0] irq_en,
  input  logic            ext_en,
  input  logic            rd_stb,
  input  logic            fcr_wr,
  input  logic            fcr_fifo_bit,
  output logic [7:0]      rd_data,
  output logic            irq_n
);
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   grant;
  logic              any;
  logic [CODE_W-1:0] code;
  logic              tx_pend, xo_pend, fl_pend;
  logic              fifo_en;
  logic              rd_q;
  logic              rd_rise;
  logic [7:0]        live;
  logic              gate_xo, gate_fl;

  assign rd_rise = rd_stb & ~rd_q;
  assign gate_xo = ext_en & irq_en[RK_XO];
  assign gate_fl = ext_en & irq_en[RK_FL];

  assign pend[RK_LS]   = req_ls    & irq_en[RK_LS];
  assign pend[RK_RTO]  = req_rto   & irq_en[RK_RTO];
  assign pend[RK_RXR]  = req_rxrdy & irq_en[RK_RXR];
  assign pend[RK_TX]   = tx_pend   & irq_en[RK_TX];
  assign pend[RK_MS]   = req_ms    & irq_en[RK_MS];
  assign pend[RK_GPIO] = req_gpio  & irq_en[RK_GPIO];
  assign pend[RK_XO]   = xo_pend   & gate_xo;
  assign pend[RK_FL]   = fl_pend   & gate_fl;

  uirq_prio #(.N(NSRC)) u_prio (
    .pend  (pend),
    .grant (grant),
    .any   (any),
    .code  (code)
  );

  uirq_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_txe  (ev_txe),
    .ev_xoff (ev_xoff),
    .ev_spec (ev_spec),
    .ev_xon  (ev_xon),
    .ev_flow (ev_flow),
    .gate_xo (gate_xo),
    .gate_fl (gate_fl),
    .rd_rise (rd_rise),
    .rep_tx  (grant[RK_TX]),
    .rep_xo  (grant[RK_XO]),
    .rep_fl  (grant[RK_FL]),
    .tx_pend (tx_pend),
    .xo_pend (xo_pend),
    .fl_pend (fl_pend)
  );

  uirq_fcr u_fcr (
    .clk          (clk),
    .rst_n        (rst_n),
    .fcr_wr       (fcr_wr),
    .fcr_fifo_bit (fcr_fifo_bit),
    .fifo_en      (fifo_en)
  );

  assign live  = {fifo_en, fifo_en, code};
  assign irq_n = live[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      rd_data <= {2'b00, CODE_IDLE};
    end else begin
      rd_q <= rd_stb;
      if (rd_rise) rd_data <= live;
    end
  end

  a_r9_capture_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> (rd_data[0] == $past(irq_n)));
  a_r9_hold_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_q) |-> $stable(rd_data));
  a_r3_irq_vs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> irq_n);
endmodule

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_ls = 0, req_rto = 0, req_rxrdy = 0, req_ms = 0, req_gpio = 0;
  logic       ev_txe = 0, ev_xoff = 0, ev_spec = 0, ev_xon = 0, ev_flow = 0;
  logic [7:0] irq_en = 8'h00;
  logic       ext_en = 0;
  logic       rd_stb = 0;
  logic       fcr_wr = 0;
  logic       fcr_fifo_bit = 0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] ff = 8'h00;

  always #4 clk = ~clk;

  uart_irq_status dut (
    .clk(clk), .rst_n(rst_n),
    .req_ls(req_ls), .req_rto(req_rto), .req_rxrdy(req_rxrdy),
    .req_ms(req_ms), .req_gpio(req_gpio),
    .ev_txe(ev_txe), .ev_xoff(ev_xoff), .ev_spec(ev_spec),
    .ev_xon(ev_xon), .ev_flow(ev_flow),
    .irq_en(irq_en), .ext_en(ext_en), .rd_stb(rd_stb),
    .fcr_wr(fcr_wr), .fcr_fifo_bit(fcr_fifo_bit),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) v = rd_data;
    rd_stb = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(v);
    check(req, v, exp | ff);
  endtask

  task automatic fire(input int which);
    @(negedge clk);
    case (which)
      0: ev_txe = 1'b1;
      1: ev_xoff = 1'b1;
      2: ev_spec = 1'b1;
      3: ev_xon = 1'b1;
      default: ev_flow = 1'b1;
    endcase
    @(negedge clk);
    {ev_txe, ev_xoff, ev_spec, ev_xon, ev_flow} = '0;
  endtask

  task automatic fcr(input logic b);
    @(negedge clk) fcr_wr = 1'b1; fcr_fifo_bit = b;
    @(negedge clk) fcr_wr = 1'b0;
    ff = b ? 8'hC0 : 8'h00;
  endtask

  task automatic t_reset;
    check("R1 rd_data", rd_data, 8'h01);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_fifo;
    fcr(1'b1);
    rd_chk("R4 fifo on", 8'h01);
    fcr(1'b0);
    rd_chk("R4 fifo off", 8'h01);
    fcr(1'b1);
  endtask

  task automatic t_priority;
    irq_en = 8'hFF; ext_en = 1'b1;
    @(negedge clk);
    req_ls = 1; req_rto = 1; req_rxrdy = 1; req_ms = 1; req_gpio = 1;
    fire(0); fire(1); fire(4);
    rd_chk("R2 line status", 8'h06);
    check("R3 irq_n low", {7'd0, irq_n}, 8'h00);
    req_ls = 0;
    rd_chk("R2 rx timeout", 8'h0C);
    req_rto = 0;
    rd_chk("R2 rx ready", 8'h04);
    req_rxrdy = 0;
    rd_chk("R2 tx ready", 8'h02);
    rd_chk("R2 modem", 8'h00);
    req_ms = 0;
    rd_chk("R2 gpio", 8'h30);
    req_gpio = 0;
    rd_chk("R2 xoff", 8'h10);
    rd_chk("R7 xoff survives read", 8'h10);
    fire(3);
    rd_chk("R2 flow pin", 8'h20);
    rd_chk("R8 flow cleared by read", 8'h01);
    check("R3 irq_n high", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_tx;
    fire(0);
    check("R3 irq_n after txe", {7'd0, irq_n}, 8'h00);
    rd_chk("R5 tx set", 8'h02);
    rd_chk("R5 tx cleared", 8'h01);
    rd_chk("R5 tx stays clear", 8'h01);
    fire(0);
    rd_chk("R5 tx re-set", 8'h02);
    rd_chk("R5 tx cleared again", 8'h01);
  endtask

  task automatic t_gate;
    ext_en = 1'b0;
    fire(1); fire(2); fire(4);
    rd_chk("R6 xoff ignored ext off", 8'h01);
    ext_en = 1'b1; irq_en[6] = 1'b0; irq_en[7] = 1'b0;
    fire(1); fire(4);
    irq_en = 8'hFF;
    rd_chk("R6 R8 ignored enable off", 8'h01);
  endtask

  task automatic t_special;
    fire(2);
    rd_chk("R7 special set", 8'h10);
    rd_chk("R7 special cleared by read", 8'h01);
    fire(2);
    fire(3);
    rd_chk("R7 special survives xon", 8'h10);
    fire(1);
    fire(3);
    rd_chk("R7 xoff cleared by xon", 8'h01);
  endtask

  task automatic t_mask;
    irq_en = 8'hFE;
    @(negedge clk) req_ls = 1'b1;
    @(negedge clk);
    check("R10 masked irq_n", {7'd0, irq_n}, 8'h01);
    rd_chk("R10 masked status", 8'h01);
    req_ls = 1'b0;
    irq_en = 8'hFF;
  endtask

  task automatic t_hold;
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) req_ls = 1'b1;
    @(negedge clk);
    check("R9 held during strobe", rd_data, 8'h01 | ff);
    check("R3 irq_n live", {7'd0, irq_n}, 8'h00);
    rd_stb = 1'b0;
    rd_chk("R9 next read", 8'h06);
    req_ls = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fifo();
    t_priority();
    t_tx();
    t_gate();
    t_special();
    t_mask();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule